// File: doc/BRIEF.md
# Simulated Echo Pulse Generator

This block stands in for the sea floor when a depth sounder is bench-tested. The sounder under test pulls an active-low trigger line. On a falling edge of that line, while no sequence is running, the block waits for a time that matches the programmed depth. It then raises its echo output for a programmed width. This delay-then-pulse pair repeats a programmed number of times per trigger, after which the block waits for the next trigger.

Depth is set with four BCD digits and a unit input that selects metres or centimetres. The block turns that value into a count of delay ticks. Each tick is the round-trip time of sound at 1500 m/s over a 10 cm depth step, about 133 µs. With the default 12 MHz clock, that is 133 steps of a 1 µs timebase. The echo width is one BCD digit in milliseconds, counted as ten 100 µs steps per millisecond. The repeat count is a further BCD digit.

All settings are captured when a trigger is accepted. While a sequence runs, a busy output is high and further triggers are ignored.

Top module: `echo_sim_top`

## Requirements
- R1: The tick count n is formed from `depth_bcd`, which holds four BCD digits with the thousands digit in bits 15:12 and the units digit in bits 3:0. With `unit_m` high (metres), n is the decimal value times 10. With `unit_m` low (centimetres), n is the decimal value divided by 10, truncated, so the units digit has no effect.
- R2: The first echo rises exactly n × DELAY_US × CLK_PER_US clock cycles after the edge at which the trigger is accepted.
- R3: Each echo pulse stays high for exactly m × WTICKS_PER_MS × WIDTH_US × CLK_PER_US cycles, where m is the value 1 to 9 of `width_bcd`.
- R4: Each accepted trigger produces exactly r pulses, where r is the value 1 to 9 of `repeat_bcd`. Every pulse after the first starts a full delay (as in R2) after the previous pulse falls.
- R5: `trig_n` is active low and passes through a two-flop synchronizer. A falling edge is accepted while idle, and `busy` is high after the third rising clock edge at which `trig_n` is seen low or has been seen low.
- R6: Falling edges of `trig_n` while `busy` is high have no effect on the pulse train. A trigger held low through the end of a sequence does not start a new one.
- R7: If n is 0, m is 0 or r is 0, the trigger is not accepted: `busy` and `echo` stay low.
- R8: `busy` stays high from acceptance until the last pulse ends. It falls at the same edge as the last echo falls, and `echo` is never high while `busy` is low.
- R9: Depth, unit, width and repeat inputs are captured at acceptance. Changing them during a sequence does not alter it.
- R10: After reset, `echo` and `busy` are low.
- R11: The timebase prescaler restarts at acceptance, so R2 to R4 timing is exact whatever the clock phase at which the trigger arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (default 12 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| trig_n | input | 1 | Active-low trigger from the sounder under test (asynchronous) |
| unit_m | input | 1 | Depth unit: 1 = metres, 0 = centimetres |
| depth_bcd | input | 16 | Depth, four BCD digits, thousands digit at bits 15:12 |
| width_bcd | input | 4 | Echo width in milliseconds, BCD 1 to 9 |
| repeat_bcd | input | 4 | Pulses per trigger, BCD 1 to 9 |
| echo | output | 1 | Simulated echo, high during each pulse |
| busy | output | 1 | High while a delay/pulse sequence is running |

## Verification
Taking the clock edge that accepts the trigger as A, `busy` is due after the third rising edge following the fall of `trig_n`. Pulse k (counting from 0) rises at A + (k+1)·D + k·W and falls at A + (k+1)·(D+W). Here D = n·DELAY_US·CLK_PER_US and W = m·WTICKS_PER_MS·WIDTH_US·CLK_PER_US, and `busy` falls with the last pulse. The bench shrinks the timebase parameters so that whole sweeps fit. It numbers the falling clock edges from the one after it drives the trigger low, records the index at which each output changes, and compares every index with these formulas. Triggers rejected for a zero setting, and triggers sent during a sequence, are checked by watching `busy` and `echo` over a window longer than a full sequence would take.

// File: rtl/echo_pkg.sv
package echo_pkg;

    // Tick count range: 9999 m * 10 = 99990 ticks of 10 cm each.
    localparam int NCNT_W = 17;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PULSE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [NCNT_W-1:0] ticks;     // delay ticks per pulse
        logic [3:0]        width_ms;  // pulse width, milliseconds
        logic [3:0]        repeats;   // pulses per trigger
    } echo_cfg_t;

    // Depth digits to 10 cm ticks. Centimetre mode drops the units digit,
    // which is exactly a truncating divide by ten.
    function automatic logic [NCNT_W-1:0] depth_to_ticks(
        input logic [15:0] bcd,
        input logic        metres
    );
        logic [NCNT_W-1:0] upper;
        logic [NCNT_W-1:0] whole;
        upper = NCNT_W'(bcd[15:12]) * NCNT_W'(100)
              + NCNT_W'(bcd[11:8])  * NCNT_W'(10)
              + NCNT_W'(bcd[7:4]);
        whole = upper * NCNT_W'(10) + NCNT_W'(bcd[3:0]);
        return metres ? whole * NCNT_W'(10) : upper;
    endfunction

endpackage

// File: rtl/echo_trig_edge.sv
module echo_trig_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_n,
    output logic fall
);
    // SYNC_STAGES flops synchronize, one more holds the previous value.
    logic [SYNC_STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '1;
        else     shreg <= {shreg[SYNC_STAGES-1:0], trig_n};
    end

    assign fall = shreg[SYNC_STAGES] & ~shreg[SYNC_STAGES-1];
endmodule

// File: rtl/echo_timebase.sv
module echo_timebase #(
    parameter int CLK_PER_US = 12,
    parameter int DELAY_US   = 133,
    parameter int WIDTH_US   = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,        // low clears prescaler and step counter
    input  logic sel_width,  // 1: width step, 0: delay step
    output logic tick
);
    localparam int MAX_US = (DELAY_US > WIDTH_US) ? DELAY_US : WIDTH_US;
    localparam int US_W   = $clog2(MAX_US + 1);

    logic us_pulse;

    generate
        if (CLK_PER_US == 1) begin : g_no_pre
            assign us_pulse = run;
        end else begin : g_pre
            localparam int PRE_W = $clog2(CLK_PER_US);
            logic [PRE_W-1:0] pre_cnt;
            always_ff @(posedge clk) begin
                if (rst || !run)                            pre_cnt <= '0;
                else if (pre_cnt == PRE_W'(CLK_PER_US - 1)) pre_cnt <= '0;
                else                                        pre_cnt <= pre_cnt + 1'b1;
            end
            assign us_pulse = run && (pre_cnt == PRE_W'(CLK_PER_US - 1));
        end
    endgenerate

    logic [US_W-1:0] us_cnt;
    logic [US_W-1:0] us_last;

    assign us_last = sel_width ? US_W'(WIDTH_US - 1) : US_W'(DELAY_US - 1);

    always_ff @(posedge clk) begin
        if (rst || !run)       us_cnt <= '0;
        else if (us_pulse) begin
            if (us_cnt == us_last) us_cnt <= '0;
            else                   us_cnt <= us_cnt + 1'b1;
        end
    end

    assign tick = us_pulse && (us_cnt == us_last);
endmodule

// File: rtl/echo_seq.sv
module echo_seq
    import echo_pkg::*;
#(
    parameter int WTICKS_PER_MS = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  echo_cfg_t cfg_in,
    input  logic      tick,
    output logic      echo,
    output logic      busy,
    output echo_cfg_t cfg_o,
    output logic [3:0] rep_o
);
    localparam int WLIM_W = $clog2(9 * WTICKS_PER_MS + 1);

    seq_state_e        state;
    echo_cfg_t         cfg_q;
    logic [NCNT_W-1:0] ph_cnt;
    logic [3:0]        rep_q;
    logic [WLIM_W-1:0] wlim;
    logic              cfg_ok;
    logic              delay_done;
    logic              width_done;

    assign cfg_ok = (cfg_in.ticks != '0) && (cfg_in.width_ms != '0)
                 && (cfg_in.repeats != '0);

    assign wlim       = WLIM_W'(cfg_q.width_ms) * WLIM_W'(WTICKS_PER_MS);
    assign delay_done = tick && (ph_cnt == cfg_q.ticks - 1'b1);
    assign width_done = tick && (ph_cnt == NCNT_W'(wlim) - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cfg_q  <= '0;
            ph_cnt <= '0;
            rep_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (fire && cfg_ok) begin
                        cfg_q  <= cfg_in;
                        ph_cnt <= '0;
                        rep_q  <= '0;
                        state  <= ST_DELAY;
                    end
                end
                ST_DELAY: begin
                    if (delay_done) begin
                        ph_cnt <= '0;
                        state  <= ST_PULSE;
                    end else if (tick) begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (width_done) begin
                        ph_cnt <= '0;
                        if (rep_q == cfg_q.repeats - 1'b1) begin
                            rep_q <= '0;
                            state <= ST_IDLE;
                        end else begin
                            rep_q <= rep_q + 1'b1;
                            state <= ST_DELAY;
                        end
                    end else if (tick) begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign echo  = (state == ST_PULSE);
    assign busy  = (state != ST_IDLE);
    assign cfg_o = cfg_q;
    assign rep_o = rep_q;
endmodule

// File: rtl/echo_sim_top.sv
module echo_sim_top
    import echo_pkg::*;
#(
    parameter int CLK_PER_US    = 12,
    parameter int DELAY_US      = 133,
    parameter int WIDTH_US      = 100,
    parameter int WTICKS_PER_MS = 10,
    parameter int SYNC_STAGES   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        trig_n,
    input  logic        unit_m,
    input  logic [15:0] depth_bcd,
    input  logic [3:0]  width_bcd,
    input  logic [3:0]  repeat_bcd,
    output logic        echo,
    output logic        busy
);
    logic      fall;
    logic      tick;
    echo_cfg_t cfg_in;
    echo_cfg_t cfg_q;
    logic [3:0] rep_q;

    assign cfg_in.ticks    = depth_to_ticks(depth_bcd, unit_m);
    assign cfg_in.width_ms = width_bcd;
    assign cfg_in.repeats  = repeat_bcd;

    echo_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .trig_n (trig_n),
        .fall   (fall)
    );

    echo_timebase #(
        .CLK_PER_US (CLK_PER_US),
        .DELAY_US   (DELAY_US),
        .WIDTH_US   (WIDTH_US)
    ) u_tb (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .sel_width (echo),
        .tick      (tick)
    );

    echo_seq #(.WTICKS_PER_MS(WTICKS_PER_MS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .fire   (fall),
        .cfg_in (cfg_in),
        .tick   (tick),
        .echo   (echo),
        .busy   (busy),
        .cfg_o  (cfg_q),
        .rep_o  (rep_q)
    );
endmodule

// File: rtl/echo_sim_chk.sv
module echo_sim_chk
    import echo_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      echo,
    input logic      busy,
    input echo_cfg_t cfg_q,
    input logic [3:0] rep_q
);
    // R8: echo only inside a busy window
    p_echo_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
        echo |-> busy);

    // R8: busy ends together with the last pulse
    p_busy_ends_with_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $fell(echo));

    // R2: a sequence opens with a delay, never with the echo already high
    p_delay_first_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !echo);

    // R7: no sequence starts on a zero setting
    p_zero_rejected_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cfg_q.ticks != '0 && cfg_q.width_ms != '0
                         && cfg_q.repeats != '0));

    // R9: captured settings hold for the whole sequence
    p_cfg_held_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));

    // R4: pulse index never reaches the repeat count
    p_rep_bound_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rep_q < cfg_q.repeats));
endmodule

bind echo_sim_top echo_sim_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .echo  (echo),
    .busy  (busy),
    .cfg_q (cfg_q),
    .rep_q (rep_q)
);

// File: tb/tb_echo_sim_top.sv
module tb_echo_sim_top;
    localparam int P  = 2;   // clocks per microsecond step
    localparam int DU = 3;   // steps per delay tick
    localparam int WU = 2;   // steps per width tick
    localparam int WT = 10;  // width ticks per millisecond

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_n = 1'b1;
    logic        unit_m = 1'b0;
    logic [15:0] depth_bcd = '0;
    logic [3:0]  width_bcd = '0;
    logic [3:0]  repeat_bcd = '0;
    logic        echo;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    echo_sim_top #(
        .CLK_PER_US    (P),
        .DELAY_US      (DU),
        .WIDTH_US      (WU),
        .WTICKS_PER_MS (WT),
        .SYNC_STAGES   (2)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .trig_n     (trig_n),
        .unit_m     (unit_m),
        .depth_bcd  (depth_bcd),
        .width_bcd  (width_bcd),
        .repeat_bcd (repeat_bcd),
        .echo       (echo),
        .busy       (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1 reference: decimal value, then unit scaling
    function automatic int ref_ticks(input logic um, input logic [15:0] d);
        int v;
        v = d[15:12] * 1000 + d[11:8] * 100 + d[7:4] * 10 + d[3:0];
        return um ? v * 10 : v / 10;
    endfunction

    task automatic run_seq(input logic um, input logic [15:0] dep,
                           input int w, input int r, input int pre_wait,
                           input int retrig_at, input bit scramble,
                           input bit hold_low, input string tag);
        int n, dcy, wcy, t, k, limit;
        logic pb, pe;
        n   = ref_ticks(um, dep);
        dcy = n * DU * P;
        wcy = w * WT * WU * P;
        limit = 3 + r * (dcy + wcy) + 40;
        repeat (pre_wait) @(negedge clk);
        unit_m = um; depth_bcd = dep;
        width_bcd = 4'(w); repeat_bcd = 4'(r);
        @(negedge clk);
        trig_n = 1'b0;
        t = 0; k = 0; pb = busy; pe = echo;
        while (1) begin
            @(negedge clk);
            t++;
            if (busy && !pb) chk(t == 3, "R5 busy rise", t, 3);
            if (echo && !pe) begin
                if (k == 0) chk(t == 3 + dcy, "R1 R2 first echo", t, 3 + dcy);
                else        chk(t == 3 + (k + 1) * dcy + k * wcy, "R4 later echo",
                                t, 3 + (k + 1) * dcy + k * wcy);
            end
            if (!echo && pe) begin
                chk(t == 3 + (k + 1) * (dcy + wcy), "R3 echo fall",
                    t, 3 + (k + 1) * (dcy + wcy));
                k++;
            end
            if (!busy && pb) begin
                chk(t == 3 + r * (dcy + wcy), "R8 busy fall", t, 3 + r * (dcy + wcy));
                break;
            end
            if (t > limit) begin
                chk(1'b0, "R8 sequence end", t, limit);
                break;
            end
            pb = busy; pe = echo;
            if (t == 2 && !hold_low) trig_n = 1'b1;
            if (retrig_at != 0 && t == retrig_at)     trig_n = 1'b0;
            if (retrig_at != 0 && t == retrig_at + 3) trig_n = 1'b1;
            if (scramble && t == 5) begin
                unit_m = ~um; depth_bcd = 16'h0001;
                width_bcd = 4'd9; repeat_bcd = 4'd9;
            end
        end
        chk(k == r, tag, k, r);
        if (hold_low) begin
            // R6: trigger still low after the end, no restart
            begin
                bit seen;
                seen = 1'b0;
                repeat (dcy + 20) begin
                    @(negedge clk);
                    if (busy || echo) seen = 1'b1;
                end
                chk(!seen, "R6 held trigger", int'(seen), 0);
            end
            trig_n = 1'b1;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic run_zero(input logic um, input logic [15:0] dep,
                            input int w, input int r);
        bit seen;
        seen = 1'b0;
        unit_m = um; depth_bcd = dep;
        width_bcd = 4'(w); repeat_bcd = 4'(r);
        @(negedge clk);
        trig_n = 1'b0;
        repeat (3) @(negedge clk);
        trig_n = 1'b1;
        repeat (400) begin
            @(negedge clk);
            if (busy || echo) seen = 1'b1;
        end
        chk(!seen, "R7 zero setting", int'(seen), 0);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(echo == 1'b0, "R10 echo after reset", int'(echo), 0);
        chk(busy == 1'b0, "R10 busy after reset", int'(busy), 0);

        // R1: metres and centimetres, digit positions, truncation
        run_seq(1'b1, 16'h0001, 1, 1, 0, 0, 1'b0, 1'b0, "R4 count");
        run_seq(1'b0, 16'h0123, 2, 3, 1, 0, 1'b0, 1'b0, "R4 count");
        run_seq(1'b0, 16'h9999, 1, 1, 0, 0, 1'b0, 1'b0, "R1 count");
        run_seq(1'b0, 16'h0019, 1, 2, 2, 0, 1'b0, 1'b0, "R1 count");
        run_seq(1'b0, 16'h1000, 1, 1, 0, 0, 1'b0, 1'b0, "R1 count");
        run_seq(1'b1, 16'h0010, 1, 1, 3, 0, 1'b0, 1'b0, "R1 count");

        // R3 R4: widths and repeat counts swept together
        for (int j = 1; j <= 9; j++)
            run_seq(1'b0, 16'h0020, j, j, 0, 0, 1'b0, 1'b0, "R4 count");
        run_seq(1'b0, 16'h0010, 9, 9, 0, 0, 1'b0, 1'b0, "R3 count");

        // R6: extra falling edge mid-sequence
        run_seq(1'b1, 16'h0002, 3, 2, 0, 50, 1'b0, 1'b0, "R6 count");
        // R6: trigger held low through the end
        run_seq(1'b0, 16'h0055, 1, 1, 0, 0, 1'b0, 1'b1, "R6 count");
        // R9: inputs changed after acceptance
        run_seq(1'b1, 16'h0001, 1, 2, 0, 0, 1'b1, 1'b0, "R9 count");

        // R11: trigger arrival at varied phases
        for (int ph = 0; ph < 4; ph++)
            run_seq(1'b0, 16'h0037, 1, 2, ph, 0, 1'b0, 1'b0, "R11 count");

        // R7: each zero setting
        run_zero(1'b0, 16'h0009, 1, 1);
        run_zero(1'b1, 16'h0000, 1, 1);
        run_zero(1'b1, 16'h0001, 0, 1);
        run_zero(1'b1, 16'h0001, 1, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule